// File: doc/BRIEF.md
# Serial Three-X-Plus-One Arithmetic Unit

This block computes Y = 3·X + 1 on an unsigned operand that arrives one bit per accepted transfer, least significant bit first, and returns Y on a one-bit stream in the same order. It treats the product as X + 2X + 1. The 2X term is the input bit from the previous transfer, and the +1 is a carry that starts at one. A single full adder and two state flops therefore replace a parallel multiplier. Each output bit is a Mealy function of the present input bit and the held state.

Both streams use a valid/ready handshake. The unit holds no buffer, so one transfer on the input and one on the output happen together. The input is ready exactly when the output is ready and start is low. The output is valid exactly when the input is valid and start is low. A producer that raises `in_valid` must keep it raised, with `x` unchanged, until `in_ready` is high at a clock edge.

A driver sends the n bits of X and then two zero bits, and collects n+2 output bits. It pulses `start` for one cycle before each new operand.

Top module: `s3x_serial_unit`

## Requirements
- R1: After reset the held previous bit is 0 and the carry is 1, so the first accepted bit x=0 gives y=1 and the first accepted bit x=1 gives y=0.
- R2: On every accepted transfer, y is bit k of 3·X+1, where k is the index of that transfer since the last start. This is the parity of x, the previous bit and the carry. The new carry is the majority of those three and the previous bit becomes x.
- R3: When no transfer is accepted, the held state does not change, and a stalled output keeps the same y value until it is accepted.
- R4: `in_ready` equals `out_ready` while start is low, and `out_valid` equals `in_valid` while start is low. An input transfer and an output transfer always happen in the same cycle.
- R5: While `start` is high, the unit accepts no bit (`in_ready`=0 and `out_valid`=0). After the start cycle, the held previous bit is 0 and the carry is 1, whatever state was left by an unfinished operand.
- R6: For an n-bit X followed by two zero bits, the n+2 collected output bits equal 3·X+1 exactly, including X of all ones, where the carry ripples through every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Reinitialises the state for a new operand; blocks transfers for that cycle |
| in_valid | input | 1 | An operand bit is present on x |
| in_ready | output | 1 | The unit takes x at this edge |
| x | input | 1 | Operand bit, least significant bit first |
| out_valid | output | 1 | A result bit is present on y |
| out_ready | input | 1 | The consumer takes y at this edge |
| y | output | 1 | Result bit, least significant bit first |

## Verification
The bench predicts every result bit from the integer 3·X+1, then reassembles the stream and compares the full value for zero, all-ones and random operands of widths from 1 to 32. A design that preset the carry to 0 would produce 3·X. A design that dropped the ripple out of the top bit would truncate the all-ones case. Random back-pressure and valid gaps catch a state that advances on a stalled cycle, because it would skip or repeat a bit. A start issued in the middle of an operand catches a machine that keeps the stale previous bit or carry, and checks that no bit is taken during the start cycle.

// File: rtl/s3x_pkg.sv
package s3x_pkg;
  typedef struct packed {
    logic prev;   // input bit of the previous transfer: the 2X term
    logic carry;  // running carry; preset to 1 supplies the +1
  } s3x_state_t;

  localparam s3x_state_t S3X_INIT = '{prev: 1'b0, carry: 1'b1};
endpackage

// File: rtl/s3x_bit_adder.sv
module s3x_bit_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic cout_o
);
  always_comb begin
    sum_o  = a_i ^ b_i ^ c_i;
    cout_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/s3x_state_reg.sv
module s3x_state_reg
  import s3x_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       step_i,
  input  logic       bit_i,
  input  logic       carry_nxt_i,
  output s3x_state_t state_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= S3X_INIT;
    end else if (start_i) begin
      state_o <= S3X_INIT;
    end else if (step_i) begin
      state_o.prev  <= bit_i;
      state_o.carry <= carry_nxt_i;
    end
  end

  // R3: no accepted transfer, no state change
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !step_i) |=> $stable(state_o));

  // R5: start leaves the initial state behind it
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_o.prev == 1'b0 && state_o.carry == 1'b1));

  // R2: an accepted bit becomes the shifted term for the next transfer
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && step_i) |=> (state_o.prev == $past(bit_i)));
endmodule

// File: rtl/s3x_serial_unit.sv
module s3x_serial_unit
  import s3x_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  input  logic x,
  output logic out_valid,
  input  logic out_ready,
  output logic y
);
  s3x_state_t st;
  logic       sum_bit;
  logic       carry_nxt;
  logic       step;

  always_comb begin
    in_ready  = out_ready & ~start;
    out_valid = in_valid & ~start;
    step      = in_valid & in_ready;
  end

  s3x_bit_adder u_add (
    .a_i    (x),
    .b_i    (st.prev),
    .c_i    (st.carry),
    .sum_o  (sum_bit),
    .cout_o (carry_nxt)
  );

  s3x_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .step_i      (step),
    .bit_i       (x),
    .carry_nxt_i (carry_nxt),
    .state_o     (st)
  );

  assign y = sum_bit;

  // R4: input and output transfers coincide
  assert_paired_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (in_valid && in_ready));

  // R3: a stalled output with a held input keeps its bit
  assert_stall_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> ($stable(x) && !start) |-> $stable(y));
endmodule

// File: tb/s3x_serial_unit_tb_top.sv
module s3x_serial_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic x = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, y;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  s3x_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .x(x), .out_valid(out_valid),
    .out_ready(out_ready), .y(y)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // handshake rule check against current inputs (R4)
  task automatic chk_hs();
    chk("R4 in_ready", in_ready, out_ready & ~start);
    chk("R4 out_valid", out_valid, in_valid & ~start);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; x = 1'b1; out_ready = 1'b1;
    #1;
    chk("R5 no accept in_ready", in_ready, 0);
    chk("R5 no accept out_valid", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_operand(input longint val, input int w);
    longint exp = 3 * val + 1;
    longint acc = 0;
    pulse_start();
    for (int i = 0; i < w + 2; i++) begin
      logic b = (i < w) ? val[i] : 1'b0;
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'($urandom_range(0, 1)); x = ~b;
        #1; chk_hs();
      end
      while ($urandom_range(0, 2) == 0) begin
        @(negedge clk);
        in_valid = 1'b1; x = b; out_ready = 1'b0;
        #1; chk_hs();
        chk("R3 stalled bit", y, exp[i]);
      end
      @(negedge clk);
      in_valid = 1'b1; x = b; out_ready = 1'b1;
      #1; chk_hs();
      chk("R2 bit", y, exp[i]);
      acc[i] = y;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 full result", acc, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b0; in_valid = 1'b0;
    #1;
    chk("R1 reset out_valid", out_valid, 0);
    // R1: first bit after reset, x=0 -> y=1
    @(negedge clk);
    in_valid = 1'b1; x = 1'b0; out_ready = 1'b1;
    #1; chk("R1 first bit x0", y, 1);
    // R3: hold it stalled a few cycles, then a 1 after it: prev=0,carry=0 -> y=1
    @(posedge clk);
    @(negedge clk);
    x = 1'b1; out_ready = 1'b0;
    repeat (3) begin
      @(posedge clk); @(negedge clk); #1;
      chk("R3 hold", y, 1);
    end
    // R5: leave state dirty, then start mid-operand
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    run_operand(0, 1);
    run_operand(1, 1);
    run_operand(64'hF, 4);
    run_operand(64'hFFFF_FFFF, 32);   // R6 all ones
    run_operand(0, 32);
    for (int w = 1; w <= 32; w += 3) begin
      for (int k = 0; k < 4; k++) begin
        longint v = longint'({$urandom(), $urandom()}) & ((64'd1 << w) - 1);
        run_operand(v, w);
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule